// File: doc/BRIEF.md
# Signal Monitor Serial Result Port

This block takes the finished result words from a signal monitor core and shifts them out over a three-wire synchronous serial link: a serial clock, a frame sync and a data line. The monitor core hands over a power word together with a peak word and a threshold-crossing word, each of which has its own valid strobe. A power strobe closes one measurement result. The peak and threshold values that go into that result are the ones on the same cycle's strobes, or else the most recent ones seen.

The serial clock is made by dividing the system clock by 2, 4 or 8. Sleep mode holds the clock low whenever nothing is waiting to be sent or being sent. Each transfer starts with a frame sync pulse one serial clock period wide. The power word always follows the sync. The peak word and the threshold word follow it only when their own enables are set. A result that arrives while a frame is still shifting waits in a one-deep buffer. Control inputs are plain levels that a register bank elsewhere drives.

Top module: `sigmon_serial_port`

## Requirements
- R1: The divide field `div_sel` sets the serial clock period in system clocks. Code 2'b01 gives 2, code 2'b10 gives 4 and code 2'b11 gives 8. Code 2'b00 is treated like 2'b01 and gives 2.
- R2: With `sleep_en` high, `sclk` stays low while no result is pending and no frame is shifting.
- R3: With `sleep_en` low and `port_en` high, `sclk` toggles continuously. Between frames, `sdata` and `fsync` stay low.
- R4: With `port_en` low, `sclk`, `fsync` and `sdata` stay low and any frame in progress is abandoned. A result captured during that time is sent once `port_en` is set.
- R5: A frame opens with `fsync` high for exactly one serial clock period. The 20-bit power word then follows, MSB first, one bit per serial clock period.
- R6: When `peak_en` is high at the start of a frame, the 13-bit peak word follows the power word, MSB first.
- R7: When `thr_en` is high at the start of a frame, the 13-bit threshold word comes last, MSB first. It follows the peak word, or the power word if the peak word is not included.
- R8: `sdata` and `fsync` change only on a falling edge of `sclk`, so they are stable at every rising edge.
- R9: A result that arrives while a frame is shifting is sent in the frame that comes straight after it. No result is lost while the buffer has room.
- R10: If a second result arrives before the buffered one has started sending, the older buffered result is dropped and the newer one is sent.
- R11: Peak and threshold strobes that come without a power strobe update held values. The next power strobe sends those held values, unless a new value is strobed on that same cycle.
- R12: After reset, `sclk`, `fsync` and `sdata` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Master enable for the serial output |
| peak_en | input | 1 | Include the peak word in frames |
| thr_en | input | 1 | Include the threshold-crossing word in frames |
| div_sel | input | 2 | Serial clock divide code |
| sleep_en | input | 1 | Hold the serial clock low when there is nothing to send |
| pwr_val | input | 20 | Power result word |
| pwr_vld | input | 1 | Power strobe; closes one result |
| peak_val | input | 13 | Peak result word |
| peak_vld | input | 1 | Peak strobe |
| thr_val | input | 13 | Threshold-crossing result word |
| thr_vld | input | 1 | Threshold strobe |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync, one serial clock period wide |
| sdata | output | 1 | Serial data, MSB first |

## Verification
A wrong divider count shows at once as a serial clock period that does not match the divide code at the next rising edge. A wrong shift length or word order corrupts the frame being sent. Either error is caught when the receiver in the bench compares that frame bit by bit against the value it rebuilt on its own. A buffer flag that gets stuck or is cleared too early shows up as an extra frame, a missing frame or a repeated frame within one frame time. A wrong gating decision shows as clock edges during sleep, or as idle data that is not low, on the very next system clock.

// File: rtl/sigmon_sp_pkg.sv
`timescale 1ns/1ps
package sigmon_sp_pkg;

    localparam int PWR_W_DEF = 20;
    localparam int PK_W_DEF  = 13;
    localparam int TH_W_DEF  = 13;
    localparam int HALF_W    = 3;

    typedef enum logic [1:0] {
        DIV_BY2_ALT = 2'b00,
        DIV_BY2     = 2'b01,
        DIV_BY4     = 2'b10,
        DIV_BY8     = 2'b11
    } div_code_e;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_SYNC = 2'd1,
        SH_DATA = 2'd2
    } sh_state_e;

    // System clocks per half period of the serial clock.
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] code);
        case (div_code_e'(code))
            DIV_BY4: half_period = HALF_W'(2);
            DIV_BY8: half_period = HALF_W'(4);
            default: half_period = HALF_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/sigmon_sp_clkdiv.sv
`timescale 1ns/1ps
module sigmon_sp_clkdiv
    import sigmon_sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       sclk,
    output logic       fall_tick
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              terminal;

    always_comb begin
        half      = half_period(div_sel);
        // >= keeps the counter from running past the limit after a divide change
        terminal  = (cnt >= half - HALF_W'(1));
        fall_tick = run && terminal && sclk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (terminal) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + HALF_W'(1);
        end
    end
endmodule

// File: rtl/sigmon_sp_capture.sv
`timescale 1ns/1ps
module sigmon_sp_capture #(
    parameter int PWR_W = 20,
    parameter int PK_W  = 13,
    parameter int TH_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWR_W-1:0] pwr_val,
    input  logic             pwr_vld,
    input  logic [PK_W-1:0]  peak_val,
    input  logic             peak_vld,
    input  logic [TH_W-1:0]  thr_val,
    input  logic             thr_vld,
    input  logic             take,
    output logic             pend,
    output logic [PWR_W-1:0] pend_pwr,
    output logic [PK_W-1:0]  pend_pk,
    output logic [TH_W-1:0]  pend_th
);
    logic [PK_W-1:0] pk_hold;
    logic [TH_W-1:0] th_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pk_hold  <= '0;
            th_hold  <= '0;
            pend     <= 1'b0;
            pend_pwr <= '0;
            pend_pk  <= '0;
            pend_th  <= '0;
        end else begin
            if (peak_vld) pk_hold <= peak_val;
            if (thr_vld)  th_hold <= thr_val;
            if (pwr_vld) begin
                // overwrites any result still waiting: the newest one wins
                pend     <= 1'b1;
                pend_pwr <= pwr_val;
                pend_pk  <= peak_vld ? peak_val : pk_hold;
                pend_th  <= thr_vld  ? thr_val  : th_hold;
            end else if (take) begin
                pend     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sigmon_sp_shifter.sv
`timescale 1ns/1ps
module sigmon_sp_shifter
    import sigmon_sp_pkg::*;
#(
    parameter int PWR_W = 20,
    parameter int PK_W  = 13,
    parameter int TH_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             tick,
    input  logic             pk_en,
    input  logic             th_en,
    input  logic             pend,
    input  logic [PWR_W-1:0] pend_pwr,
    input  logic [PK_W-1:0]  pend_pk,
    input  logic [TH_W-1:0]  pend_th,
    output logic             take,
    output logic             busy,
    output logic             fsync,
    output logic             sdata
);
    localparam int FRM_W = PWR_W + PK_W + TH_W;
    localparam int LEN_W = $clog2(FRM_W + 1);

    sh_state_e        state;
    logic [FRM_W-1:0] shreg;
    logic [LEN_W-1:0] left;
    logic [FRM_W-1:0] start_vec;
    logic [LEN_W-1:0] start_len;
    logic             last_bit;

    // Words are left-justified so the frame always shifts out of the top bit.
    function automatic logic [FRM_W-1:0] pack(
        input logic [PWR_W-1:0] p, input logic [PK_W-1:0] k,
        input logic [TH_W-1:0] t, input logic ke, input logic te);
        case ({ke, te})
            2'b11:   pack = {p, k, t};
            2'b10:   pack = {p, k, {TH_W{1'b0}}};
            2'b01:   pack = {p, t, {PK_W{1'b0}}};
            default: pack = {p, {(PK_W + TH_W){1'b0}}};
        endcase
    endfunction

    always_comb begin
        start_vec = pack(pend_pwr, pend_pk, pend_th, pk_en, th_en);
        start_len = LEN_W'(PWR_W)
                  + (pk_en ? LEN_W'(PK_W) : LEN_W'(0))
                  + (th_en ? LEN_W'(TH_W) : LEN_W'(0));
        last_bit  = (state == SH_DATA) && (left == '0);
        take      = tick && port_en && pend && ((state == SH_IDLE) || last_bit);
        busy      = (state != SH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst || !port_en) begin
            state <= SH_IDLE;
            shreg <= '0;
            left  <= '0;
            fsync <= 1'b0;
            sdata <= 1'b0;
        end else if (tick) begin
            if (take) begin
                state <= SH_SYNC;
                shreg <= start_vec;
                left  <= start_len - LEN_W'(1);
                fsync <= 1'b1;
                sdata <= 1'b0;
            end else begin
                case (state)
                    SH_SYNC: begin
                        state <= SH_DATA;
                        fsync <= 1'b0;
                        sdata <= shreg[FRM_W-1];
                        shreg <= shreg << 1;
                    end
                    SH_DATA: begin
                        if (left == '0) begin
                            state <= SH_IDLE;
                            sdata <= 1'b0;
                        end else begin
                            sdata <= shreg[FRM_W-1];
                            shreg <= shreg << 1;
                            left  <= left - LEN_W'(1);
                        end
                    end
                    default: begin
                        state <= SH_IDLE;
                        sdata <= 1'b0;
                        fsync <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sigmon_serial_port.sv
`timescale 1ns/1ps
module sigmon_serial_port
    import sigmon_sp_pkg::*;
#(
    parameter int PWR_W = PWR_W_DEF,
    parameter int PK_W  = PK_W_DEF,
    parameter int TH_W  = TH_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_en,
    input  logic             peak_en,
    input  logic             thr_en,
    input  logic [1:0]       div_sel,
    input  logic             sleep_en,
    input  logic [PWR_W-1:0] pwr_val,
    input  logic             pwr_vld,
    input  logic [PK_W-1:0]  peak_val,
    input  logic             peak_vld,
    input  logic [TH_W-1:0]  thr_val,
    input  logic             thr_vld,
    output logic             sclk,
    output logic             fsync,
    output logic             sdata
);
    logic             run;
    logic             tick;
    logic             take;
    logic             busy;
    logic             pend;
    logic [PWR_W-1:0] pend_pwr;
    logic [PK_W-1:0]  pend_pk;
    logic [TH_W-1:0]  pend_th;

    // Clock runs when enabled, unless sleeping with nothing to send.
    assign run = port_en && (!sleep_en || busy || pend);

    sigmon_sp_clkdiv u_clkdiv (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .div_sel   (div_sel),
        .sclk      (sclk),
        .fall_tick (tick)
    );

    sigmon_sp_capture #(.PWR_W(PWR_W), .PK_W(PK_W), .TH_W(TH_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .pwr_val  (pwr_val),
        .pwr_vld  (pwr_vld),
        .peak_val (peak_val),
        .peak_vld (peak_vld),
        .thr_val  (thr_val),
        .thr_vld  (thr_vld),
        .take     (take),
        .pend     (pend),
        .pend_pwr (pend_pwr),
        .pend_pk  (pend_pk),
        .pend_th  (pend_th)
    );

    sigmon_sp_shifter #(.PWR_W(PWR_W), .PK_W(PK_W), .TH_W(TH_W)) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .port_en  (port_en),
        .tick     (tick),
        .pk_en    (peak_en),
        .th_en    (thr_en),
        .pend     (pend),
        .pend_pwr (pend_pwr),
        .pend_pk  (pend_pk),
        .pend_th  (pend_th),
        .take     (take),
        .busy     (busy),
        .fsync    (fsync),
        .sdata    (sdata)
    );
endmodule

// File: rtl/sigmon_sp_checker.sv
`timescale 1ns/1ps
module sigmon_sp_checker (
    input logic clk,
    input logic rst,
    input logic port_en,
    input logic sleep_en,
    input logic sclk,
    input logic fsync,
    input logic sdata,
    input logic busy,
    input logic pend
);
    // R2: asleep with nothing to do keeps the serial clock low
    p_sleep_low_r2: assert property (@(posedge clk) disable iff (rst)
        (port_en && sleep_en && !busy && !pend) |=> !sclk);

    // R3: outside a frame the data and sync lines are quiet
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sdata && !fsync));

    // R4: disabled port drives all outputs low on the next cycle
    p_port_off_r4: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (!sclk && !fsync && !sdata));

    // R5: frame sync edges line up with serial clock falls
    p_fsync_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (port_en && $past(port_en) && !$stable(fsync)) |-> ($past(sclk) && !sclk));

    // R8: data changes only where the serial clock falls
    p_data_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (port_en && $past(port_en) && !$stable(sdata)) |-> ($past(sclk) && !sclk));
endmodule

bind sigmon_serial_port sigmon_sp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .port_en  (port_en),
    .sleep_en (sleep_en),
    .sclk     (sclk),
    .fsync    (fsync),
    .sdata    (sdata),
    .busy     (busy),
    .pend     (pend)
);

// File: tb/sigmon_serial_port_bench.sv
`timescale 1ns/1ps
module sigmon_serial_port_bench;
    localparam int PW = 20;
    localparam int KW = 13;
    localparam int TW = 13;
    localparam int FW = PW + KW + TW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          port_en = 1'b0, peak_en = 1'b0, thr_en = 1'b0, sleep_en = 1'b0;
    logic [1:0]    div_sel = 2'b01;
    logic [PW-1:0] pwr_val = '0;
    logic [KW-1:0] peak_val = '0;
    logic [TW-1:0] thr_val = '0;
    logic          pwr_vld = 1'b0, peak_vld = 1'b0, thr_vld = 1'b0;
    logic          sclk, fsync, sdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [FW-1:0] exp_q[$];
    int            len_q[$];
    logic [KW-1:0] m_pk = '0;
    logic [TW-1:0] m_th = '0;

    // receiver state
    logic          sclk_d = 1'b0;
    bit            rx_on = 1'b0, rx_bad = 1'b0;
    int            rx_n = 0;
    logic [FW-1:0] rx_v = '0;
    int            idle_err = 0, rises = 0, frames = 0;

    always #5 clk = ~clk;

    sigmon_serial_port u_sigmon_serial_port (
        .clk(clk), .rst(rst), .port_en(port_en), .peak_en(peak_en), .thr_en(thr_en),
        .div_sel(div_sel), .sleep_en(sleep_en),
        .pwr_val(pwr_val), .pwr_vld(pwr_vld), .peak_val(peak_val), .peak_vld(peak_vld),
        .thr_val(thr_val), .thr_vld(thr_vld),
        .sclk(sclk), .fsync(fsync), .sdata(sdata));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Expected frame, built bit by bit: power, then peak, then threshold.
    function automatic logic [FW-1:0] build(input logic [PW-1:0] p, input logic [KW-1:0] k,
            input logic [TW-1:0] t, input bit ke, input bit te, output int n);
        logic [FW-1:0] v = '0;
        n = 0;
        for (int i = PW - 1; i >= 0; i--) begin v[FW-1-n] = p[i]; n++; end
        if (ke) for (int i = KW - 1; i >= 0; i--) begin v[FW-1-n] = k[i]; n++; end
        if (te) for (int i = TW - 1; i >= 0; i--) begin v[FW-1-n] = t[i]; n++; end
        return v;
    endfunction

    task automatic push_exp(input logic [PW-1:0] p);
        int n;
        logic [FW-1:0] v;
        v = build(p, m_pk, m_th, peak_en, thr_en, n);
        exp_q.push_back(v);
        len_q.push_back(n);
    endtask

    // Full result: all three strobes in one cycle.
    task automatic send(input logic [PW-1:0] p, input logic [KW-1:0] k,
                        input logic [TW-1:0] t, input bit expect_it);
        @(negedge clk);
        pwr_val = p; peak_val = k; thr_val = t;
        pwr_vld = 1'b1; peak_vld = 1'b1; thr_vld = 1'b1;
        m_pk = k; m_th = t;
        if (expect_it) push_exp(p);
        @(negedge clk);
        pwr_vld = 1'b0; peak_vld = 1'b0; thr_vld = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 8000) begin @(negedge clk); guard++; end
        repeat (20) @(negedge clk);
    endtask

    task automatic meas(input logic [1:0] code, input int expv);
        int n = 0;
        logic last;
        div_sel = code;
        repeat (20) @(negedge clk);
        last = sclk;
        while (!(sclk && !last)) begin last = sclk; @(negedge clk); end
        last = sclk;
        @(negedge clk); n = 1;
        while (!(sclk && !last)) begin last = sclk; @(negedge clk); n++; end
        chk(n == expv, "R1", "serial clock period", n, expv);
    endtask

    // Receiver: samples at falling system clock, acts on serial clock rises.
    always @(negedge clk) begin
        if (rst) begin
            sclk_d = 1'b0; rx_on = 1'b0;
        end else begin
            if (sclk && !sclk_d) begin
                rises++;
                if (!rx_on) begin
                    if (fsync) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R9", "unexpected frame", 1, 0);
                        end else begin
                            rx_on = 1'b1; rx_n = 0; rx_v = '0; rx_bad = 1'b0;
                        end
                    end else if (sdata) begin
                        idle_err++;
                    end
                end else begin
                    if (fsync) rx_bad = 1'b1;
                    rx_v[FW-1-rx_n] = sdata;
                    rx_n++;
                    if (rx_n == len_q[0]) begin
                        chk(!rx_bad && rx_v == exp_q[0], "R5/R6/R7", "frame content",
                            longint'(rx_v), longint'(exp_q[0]));
                        void'(exp_q.pop_front());
                        void'(len_q.pop_front());
                        rx_on = 1'b0;
                        frames++;
                    end
                end
            end
            sclk_d = sclk;
        end
    end

    initial begin
        #1_900_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int bad;
        int f0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(!sclk && !fsync && !sdata, "R12", "outputs in reset", {sclk, fsync, sdata}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sclk && !fsync && !sdata, "R12", "outputs after reset", {sclk, fsync, sdata}, 0);

        // R1: divide ratios with the clock free-running
        port_en = 1'b1;
        meas(2'b01, 2);
        meas(2'b10, 4);
        meas(2'b11, 8);
        meas(2'b00, 2);

        // R3: idle with sleep clear, clock runs, lines quiet
        idle_err = 0; rises = 0; bad = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (fsync || sdata) bad++; end
        chk(rises > 20 && bad == 0 && idle_err == 0, "R3", "idle activity", bad, 0);

        // R5: power-only frame
        peak_en = 1'b0; thr_en = 1'b0; div_sel = 2'b01;
        send(20'hA5C3F, 13'h1ABC, 13'h0F0F, 1'b1);
        drain();
        // R6: power plus peak
        peak_en = 1'b1;
        send(20'h0137B, 13'h1FFE, 13'h0555, 1'b1);
        drain();
        // R7: power plus threshold, no peak
        peak_en = 1'b0; thr_en = 1'b1;
        send(20'hFFFFF, 13'h0001, 13'h1234, 1'b1);
        drain();

        // R2: sleep keeps the clock low when idle, then wakes for a frame
        sleep_en = 1'b1; peak_en = 1'b1; div_sel = 2'b10;
        repeat (10) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 150; i++) begin @(negedge clk); if (sclk) bad++; end
        chk(bad == 0, "R2", "clock edges while asleep", bad, 0);
        send(20'h80001, 13'h1000, 13'h0001, 1'b1);
        drain();
        bad = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (sclk) bad++; end
        chk(bad == 0, "R2", "clock low after frame", bad, 0);

        // R11: staged peak and threshold used by a later power strobe
        @(negedge clk); peak_val = 13'h0ACE; peak_vld = 1'b1; m_pk = 13'h0ACE;
        @(negedge clk); peak_vld = 1'b0; thr_val = 13'h1DAD; thr_vld = 1'b1; m_th = 13'h1DAD;
        @(negedge clk); thr_vld = 1'b0;
        repeat (5) @(negedge clk);
        pwr_val = 20'h3C3C3; pwr_vld = 1'b1; push_exp(20'h3C3C3);
        @(negedge clk); pwr_vld = 1'b0;
        drain();
        chk(exp_q.size() == 0, "R11", "staged result frame pending", exp_q.size(), 0);

        // R4: disabled port stays silent, result sent after enable
        port_en = 1'b0; sleep_en = 1'b0;
        repeat (5) @(negedge clk);
        send(20'h5A5A5, 13'h0321, 13'h1555, 1'b1);
        bad = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (sclk || fsync || sdata) bad++; end
        chk(bad == 0, "R4", "activity while disabled", bad, 0);
        f0 = frames;
        port_en = 1'b1;
        drain();
        chk(frames == f0 + 1, "R4", "held result sent after enable", frames - f0, 1);

        // R9: result arriving mid-frame follows straight after
        div_sel = 2'b11; peak_en = 1'b1; thr_en = 1'b1;
        f0 = frames;
        send(20'h11111, 13'h0222, 13'h0333, 1'b1);
        while (!fsync) @(negedge clk);
        repeat (16) @(negedge clk);
        send(20'h44444, 13'h0555, 13'h0666, 1'b1);
        drain();
        chk(frames == f0 + 2, "R9", "back-to-back frames", frames - f0, 2);

        // R10: two results during one frame, older pending one dropped
        f0 = frames;
        send(20'h77777, 13'h0888, 13'h0999, 1'b1);
        while (!fsync) @(negedge clk);
        repeat (30) @(negedge clk);
        send(20'hBBBBB, 13'h0CCC, 13'h0DDD, 1'b0);
        repeat (3) @(negedge clk);
        send(20'hEEEEE, 13'h1F1F, 13'h0E0E, 1'b1);
        drain();
        chk(frames == f0 + 2, "R10", "frames after overflow", frames - f0, 2);

        // Random results with random settings, one frame at a time (R5, R6, R7, R1)
        for (int it = 0; it < 20; it++) begin
            peak_en  = 1'($urandom);
            thr_en   = 1'($urandom);
            sleep_en = 1'($urandom);
            div_sel  = 2'($urandom);
            repeat (8) @(negedge clk);
            send(20'($urandom), 13'($urandom), 13'($urandom), 1'b1);
            drain();
        end

        chk(exp_q.size() == 0, "R9", "frames left unsent", exp_q.size(), 0);
        chk(idle_err == 0, "R3", "idle data high at clock rise", idle_err, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule